// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block decides in which clock cycles a periodic recalibration of the output-driver impedance may be applied. It sees the cycle type of every clock and the output enable. A recalibration becomes due 32 cycles after the previous one. Every cycle counts toward this, whether it is a read, a write or idle. Once an update is due, it waits until a cycle whose outputs are not being driven, then issues a one-cycle strobe and steps a modelled impedance code. Reads never stall. An update that is due simply waits.

A second counter handles power-up qualification. It counts only cycles that are not reads, and it raises a sticky "calibrated" flag when enough of them have been seen.

Top module: `zq_update_sched`

## Requirements
- R1: While rst_ni is low and after its release, until the first qualifying edge, upd_o is 0, cal_o is 0 and code_o is 0.
- R2: upd_o cannot go high earlier than the cycle that follows the 33rd rising edge after reset. Between two strobes there are always at least 33 rising edges, so a strobe is followed by at least 32 cycles without one.
- R3: cyc_i uses this encoding: 2'b00 idle/deselect, 2'b01 read, 2'b10 write, 2'b11 reserved, which is treated like a write. An edge is quiet when cyc_i is not 2'b01 or oe_i is 0. upd_o is high only in the cycle after a quiet edge. A read sampled with oe_i high is never followed by a strobe.
- R4: The interval count runs on every edge regardless of cyc_i. After 32 edges without an update, an update is pending. The pending update fires at the first quiet edge that follows, however many reads came first, and upd_o goes high in the next cycle.
- R5: upd_o is high for exactly one cycle per update.
- R6: code_o steps by 1, modulo 2^CODE_W, in the same cycle that upd_o is high, and holds its value otherwise.
- R7: cal_o rises in the cycle after the CAL_CYCLES-th edge at which cyc_i is not 2'b01 (oe_i has no effect on this count). Read edges do not count. Once high, cal_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 2 | Cycle type sampled at each rising edge |
| oe_i | input | 1 | Output enable, active high |
| upd_o | output | 1 | Impedance update strobe |
| cal_o | output | 1 | Power-up impedance qualification done |
| code_o | output | CODE_W | Modelled impedance code |

## Verification
The hardest case to reach is an update that is already pending when it meets a long run of enabled reads. To get there, the stimulus lets the interval expire inside a run of more than 33 reads with the output enable high. It checks that no strobe appears during the whole run, and that the strobe comes exactly one cycle after the first idle, write or output-disabled read. The rollover of the code and the exact edge at which the calibrated flag rises are reached by running long sequences. In those sequences reads and non-reads alternate, so read edges are visibly excluded from the qualification count.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_RSVD  = 2'b11
  } cyc_e;
endpackage

// File: rtl/zq_interval_timer.sv
module zq_interval_timer #(
  parameter int unsigned INTERVAL = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic pending_o
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] GAP_MAX  = CW'(INTERVAL);
  localparam logic [CW-1:0] GAP_LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] gap_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      pend_q <= 1'b0;
    end else if (fire_i) begin
      gap_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
      // interval expires on this edge: latch pending
      if (gap_q == GAP_LAST) pend_q <= 1'b1;
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/zq_settle_counter.sv
module zq_settle_counter #(
  parameter int unsigned CAL_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_i,
  output logic done_o
);
  localparam int unsigned NW = $clog2(CAL_CYCLES + 1);
  localparam logic [NW-1:0] CNT_MAX = NW'(CAL_CYCLES);

  logic [NW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (count_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/zq_code_gen.sv
module zq_code_gen #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (step_i) code_q <= code_q + 1'b1;
  end

  assign code_o = code_q;
endmodule

// File: rtl/zq_update_sched.sv
module zq_update_sched #(
  parameter int unsigned INTERVAL   = 32,
  parameter int unsigned CAL_CYCLES = 1024,
  parameter int unsigned CODE_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cyc_i,
  input  logic              oe_i,
  output logic              upd_o,
  output logic              cal_o,
  output logic [CODE_W-1:0] code_o
);
  import zq_sched_pkg::*;

  cyc_e cyc;
  logic is_read;
  logic quiet;
  logic pending;
  logic fire;
  logic upd_q;

  assign cyc     = cyc_e'(cyc_i);
  assign is_read = (cyc == CYC_READ);
  // outputs idle: not a read, or read with drivers disabled
  assign quiet   = !is_read || !oe_i;
  assign fire    = pending && quiet;

  zq_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .pending_o (pending)
  );

  zq_settle_counter #(.CAL_CYCLES(CAL_CYCLES)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (!is_read),
    .done_o  (cal_o)
  );

  zq_code_gen #(.CODE_W(CODE_W)) u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (fire),
    .code_o (code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= fire;
  end

  assign upd_o = upd_q;
endmodule

// File: rtl/zq_update_sched_chk.sv
module zq_update_sched_chk #(
  parameter int unsigned INTERVAL   = 32,
  parameter int unsigned CAL_CYCLES = 1024,
  parameter int unsigned CODE_W     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        cyc_i,
  input logic              oe_i,
  input logic              upd_o,
  input logic              cal_o,
  input logic [CODE_W-1:0] code_o
);
  localparam int unsigned GW = $clog2(INTERVAL + 2) + 1;
  localparam int unsigned NW = $clog2(CAL_CYCLES + 1);

  logic [GW-1:0] chk_gap;
  logic [NW-1:0] chk_nr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                chk_gap <= '0;
    else if (upd_o)             chk_gap <= GW'(1);
    else if (chk_gap != '1)     chk_gap <= chk_gap + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_nr <= '0;
    else if (cyc_i != 2'b01 && chk_nr != NW'(CAL_CYCLES)) chk_nr <= chk_nr + 1'b1;
  end

  AST_UPD_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> chk_gap > GW'(INTERVAL)); // R2
  AST_UPD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(cyc_i != 2'b01 || !oe_i)); // R3
  AST_UPD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o); // R5
  AST_CODE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_o) |-> code_o == CODE_W'($past(code_o) + 1'b1)); // R6
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(code_o)); // R6
  AST_CAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |=> cal_o); // R7
  AST_CAL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> chk_nr == NW'(CAL_CYCLES)); // R7
endmodule

bind zq_update_sched zq_update_sched_chk #(
  .INTERVAL(INTERVAL), .CAL_CYCLES(CAL_CYCLES), .CODE_W(CODE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .oe_i(oe_i),
  .upd_o(upd_o), .cal_o(cal_o), .code_o(code_o)
);

// File: tb/zq_update_sched_bench.sv
`timescale 1ns/1ps
module zq_update_sched_bench;
  localparam int CODE_W = 6;
  localparam int CAL    = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cyc = 2'b00;
  logic              oe = 1'b1;
  logic              upd;
  logic              cal;
  logic [CODE_W-1:0] code;

  int total = 0;
  int bad = 0;
  int nr = 0;
  int exp_code = 0;

  always #2.5 clk = ~clk;

  zq_update_sched u_zq_update_sched (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .oe_i(oe),
    .upd_o(upd), .cal_o(cal), .code_o(code)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(logic [1:0] c, logic e);
    cyc = c;
    oe  = e;
    @(posedge clk);
    if (c != 2'b01) nr++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc = 2'b00;
    oe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    nr = 0;
    exp_code = 0;
  endtask

  task automatic expect_fire(string req);
    exp_code = (exp_code + 1) % (1 << CODE_W);
    check(req, "upd on quiet edge", int'(upd), 1);
    check("R6", "code step", int'(code), exp_code);
  endtask

  task automatic t_reset();
    check("R1", "upd after reset", int'(upd), 0);
    check("R1", "cal after reset", int'(cal), 0);
    check("R1", "code after reset", int'(code), 0);
  endtask

  task automatic t_first_update();
    for (int i = 0; i < 32; i++) begin
      step(2'b00, 1'b1);
      check("R2", "no early upd", int'(upd), 0);
    end
    step(2'b00, 1'b1);
    expect_fire("R4");
    step(2'b00, 1'b1);
    check("R5", "strobe single cycle", int'(upd), 0);
  endtask

  // fire on last step was 1 cycle ago; 31 more edges reach the interval
  task automatic t_read_hold();
    for (int i = 0; i < 40; i++) begin
      step(2'b01, 1'b1);
      check("R3", "no upd during enabled read", int'(upd), 0);
    end
    step(2'b00, 1'b1);
    expect_fire("R4");
  endtask

  task automatic t_oe_gate();
    for (int i = 0; i < 32; i++) begin
      step(2'b01, 1'b1);
      check("R2", "no upd inside interval", int'(upd), 0);
    end
    step(2'b01, 1'b0);
    expect_fire("R3");
  endtask

  task automatic t_write_gate();
    for (int i = 0; i < 32; i++) begin
      step(2'b01, 1'b1);
      check("R3", "no upd during read", int'(upd), 0);
    end
    step(2'b10, 1'b1);
    expect_fire("R3");
  endtask

  task automatic t_spacing(int pulses);
    for (int p = 0; p < pulses; p++) begin
      for (int i = 0; i < 32; i++) begin
        step((i % 2) ? 2'b11 : 2'b00, 1'b1);
        check("R2", "min spacing", int'(upd), 0);
      end
      step(2'b00, 1'b1);
      expect_fire("R2");
    end
  endtask

  task automatic t_wrap();
    while (exp_code != 0) t_spacing(1);
    check("R6", "code wrapped to zero", int'(code), 0);
  endtask

  task automatic t_cal();
    do_reset();
    check("R1", "cal cleared by reset", int'(cal), 0);
    while (nr < CAL + 4) begin
      step(2'b01, 1'b1);
      check("R7", "cal vs non-read count (read)", int'(cal), (nr >= CAL) ? 1 : 0);
      step(2'b00, 1'b0);
      check("R7", "cal vs non-read count (idle)", int'(cal), (nr >= CAL) ? 1 : 0);
    end
    for (int i = 0; i < 10; i++) begin
      step(2'b01, 1'b1);
      check("R7", "cal sticky", int'(cal), 1);
    end
  endtask

  initial begin
    do_reset();
    t_reset();
    t_first_update();
    t_read_hold();
    t_oe_gate();
    t_write_gate();
    t_spacing(5);
    t_wrap();
    t_cal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule